// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Bank

This block watches a bank of input channels and turns activity on them into interrupt requests. Each channel can be set to one of five triggers: rising edge, falling edge, either edge, high level or low level. Software reads which channels have fired, gates them with an enable mask and acknowledges them through a small register file. Every input first passes a multi-flop synchronizer in a capture clock domain. A build-time parameter picks that domain. The fast variant samples in the bus clock itself and behaves like an ordinary synchronized GPIO input. The slow variant samples on a separate low-rate clock, typically 32 kHz, and hands each event over to the bus clock with a toggle handshake.

Three per-channel configuration bits choose the trigger. The level-select bit picks level (1) or edge (0) detection. The polarity bit picks high/rising (1) or low/falling (0). The any-edge bit, when set, makes the channel fire on every transition and overrides the other two. Trigger hits set a status bit that holds until it is acknowledged. The status bits, masked by the enable register, are ORed into one interrupt line.

Top module: `irq_bank`

## Requirements
- R1: After reset every readable register returns 0 and `irq` is low.
- R2: Register index 0 (PINS) returns the input levels delayed by the synchronizer. In the fast variant a change on `pin_in` is still absent after one rising clock edge and is visible after two.
- R3: With level-select 0, any-edge 0 and polarity 1, a 0-to-1 transition sets the channel's RAW bit. The bit stays set after the input returns low, until it is acknowledged.
- R4: With level-select 0, any-edge 0 and polarity 0, a 1-to-0 transition sets the RAW bit and a 0-to-1 transition does not.
- R5: With any-edge 1, both transitions set the RAW bit and a steady input sets nothing, whatever level-select and polarity hold.
- R6: With level-select 1 and any-edge 0, RAW is set in every cycle in which the synchronized input equals the polarity bit. An acknowledge while the level persists does not leave the bit clear, and the bit stays set after the level ends until acknowledged.
- R7: Writing index 7 (ACK) clears each RAW bit whose data bit is 1 and leaves bits written with 0 alone. A trigger hit in the same cycle as the acknowledge keeps the bit set.
- R8: PEND (index 6) equals RAW AND ENA, and `irq` is high exactly when PEND is non-zero.
- R9: Register indices: 0 PINS (read only), 1 ENA, 2 LVLSEL, 3 POLAR, 4 ANYEDGE, 5 RAW (read only), 6 PEND (read only), 7 ACK (write only, reads 0). Writes to read-only indices change nothing.
- R10: In the slow variant, a single edge on the capture clock reaches RAW through the handshake exactly once. After it is acknowledged it does not come back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; register file and status |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| cap_clk | input | 1 | Slow capture clock, used only when SLOW_CAPTURE=1 |
| pin_in | input | CHANNELS | Asynchronous channel inputs |
| wr_en | input | 1 | Write strobe for the register at `reg_idx` |
| reg_idx | input | 3 | Register index for reads and writes |
| wdata | input | CHANNELS | Write data |
| rdata | output | CHANNELS | Combinational read data of the register at `reg_idx` |
| irq | output | 1 | Combined interrupt, OR of PEND |

## Verification
The assertions assume the configuration bits are quasi-static with respect to the capture clock. They also assume the slow clock is several times slower than the bus clock, so that two toggles of one channel cannot merge in the handshake. The bench changes configuration only while the inputs are steady, runs the slow capture clock at seven bus periods, and waits well past the handshake latency before judging the slow instance. Inputs change only shortly after a bus edge, so each new value is sampled cleanly by the synchronizer.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
   localparam int IDX_W = 3;

   typedef enum logic [IDX_W-1:0] {
      IDX_PINS    = 3'd0,
      IDX_ENA     = 3'd1,
      IDX_LVLSEL  = 3'd2,
      IDX_POLAR   = 3'd3,
      IDX_ANYEDGE = 3'd4,
      IDX_RAW     = 3'd5,
      IDX_PEND    = 3'd6,
      IDX_ACK     = 3'd7
   } reg_idx_e;

   // Edge-class hit for one channel; any-edge overrides polarity.
   function automatic logic edge_fire(input logic now, input logic prev,
                                      input logic pol, input logic any);
      logic rise, fall;
      rise = now & ~prev;
      fall = ~now & prev;
      return any ? (rise | fall) : (pol ? rise : fall);
   endfunction
endpackage

// File: rtl/irqb_sync.sv
module irqb_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/irqb_capture.sv
module irqb_capture
   import irqb_pkg::*;
#(
   parameter int CH     = 8,
   parameter int STAGES = 2
) (
   input  logic          cclk,
   input  logic          rst_n,
   input  logic [CH-1:0] pin_in,
   input  logic [CH-1:0] cfg_lvl,
   input  logic [CH-1:0] cfg_pol,
   input  logic [CH-1:0] cfg_any,
   output logic [CH-1:0] now,
   output logic [CH-1:0] edge_hit,
   output logic [CH-1:0] lvl_hit
);
   logic [CH-1:0] prev_q;
   logic [CH-1:0] rise_v, fall_v;

   irqb_sync #(.W(CH), .STAGES(STAGES)) u_pin_sync (
      .clk(cclk), .rst_n(rst_n), .d(pin_in), .q(now)
   );

   always_ff @(posedge cclk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= now;
   end

   genvar c;
   generate
      for (c = 0; c < CH; c++) begin : g_chan
         assign rise_v[c]   = now[c] & ~prev_q[c];
         assign fall_v[c]   = ~now[c] & prev_q[c];
         assign edge_hit[c] = ~(cfg_lvl[c] & ~cfg_any[c]) &
                              edge_fire(now[c], prev_q[c], cfg_pol[c], cfg_any[c]);
         assign lvl_hit[c]  = cfg_lvl[c] & ~cfg_any[c] &
                              (cfg_pol[c] ? now[c] : ~now[c]);
      end
   endgenerate

   // R3: a rising transition lasts one capture cycle
   a_r3_rise_single: assert property (@(posedge cclk) disable iff (!rst_n)
      (rise_v != '0) |=> ((rise_v & $past(rise_v)) == '0));
   // R4: a falling transition lasts one capture cycle
   a_r4_fall_single: assert property (@(posedge cclk) disable iff (!rst_n)
      (fall_v != '0) |=> ((fall_v & $past(fall_v)) == '0));
endmodule

// File: rtl/irqb_xfer.sv
module irqb_xfer #(
   parameter int CH     = 8,
   parameter int STAGES = 2
) (
   input  logic          clk,
   input  logic          cclk,
   input  logic          rst_n,
   input  logic [CH-1:0] edge_hit,
   input  logic [CH-1:0] lvl_hit,
   input  logic [CH-1:0] now,
   output logic [CH-1:0] edge_bus,
   output logic [CH-1:0] lvl_bus,
   output logic [CH-1:0] pins_bus
);
   logic [CH-1:0]   tgl_q, tgl_s, tgl_d, lvl_q;
   logic [2*CH-1:0] lvl_pin_s;

   // Capture side: each edge event flips a per-channel toggle.
   always_ff @(posedge cclk or negedge rst_n) begin
      if (!rst_n) begin
         tgl_q <= '0;
         lvl_q <= '0;
      end else begin
         tgl_q <= tgl_q ^ edge_hit;
         lvl_q <= lvl_hit;
      end
   end

   irqb_sync #(.W(CH), .STAGES(STAGES)) u_tgl_sync (
      .clk(clk), .rst_n(rst_n), .d(tgl_q), .q(tgl_s)
   );

   irqb_sync #(.W(2*CH), .STAGES(STAGES)) u_lvl_sync (
      .clk(clk), .rst_n(rst_n), .d({lvl_q, now}), .q(lvl_pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tgl_d <= '0;
      else        tgl_d <= tgl_s;
   end

   assign edge_bus = tgl_s ^ tgl_d;
   assign lvl_bus  = lvl_pin_s[2*CH-1:CH];
   assign pins_bus = lvl_pin_s[CH-1:0];
endmodule

// File: rtl/irqb_regs.sv
module irqb_regs
   import irqb_pkg::*;
#(
   parameter int CH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] reg_idx,
   input  logic [CH-1:0]    wdata,
   input  logic [CH-1:0]    edge_bus,
   input  logic [CH-1:0]    lvl_bus,
   input  logic [CH-1:0]    pins_bus,
   output logic [CH-1:0]    cfg_lvl,
   output logic [CH-1:0]    cfg_pol,
   output logic [CH-1:0]    cfg_any,
   output logic [CH-1:0]    rdata,
   output logic             irq
);
   logic [CH-1:0] ena_q, lvl_q, pol_q, any_q, raw_q;
   logic [CH-1:0] ack_v, hit, pend;
   reg_idx_e      idx;

   assign idx   = reg_idx_e'(reg_idx);
   assign ack_v = (wr_en && idx == IDX_ACK) ? wdata : '0;
   assign hit   = edge_bus | lvl_bus;
   assign pend  = raw_q & ena_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ena_q <= '0;
         lvl_q <= '0;
         pol_q <= '0;
         any_q <= '0;
         raw_q <= '0;
      end else begin
         // a hit in the acknowledge cycle wins over the clear
         raw_q <= (raw_q & ~ack_v) | hit;
         if (wr_en) begin
            unique case (idx)
               IDX_ENA:     ena_q <= wdata;
               IDX_LVLSEL:  lvl_q <= wdata;
               IDX_POLAR:   pol_q <= wdata;
               IDX_ANYEDGE: any_q <= wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      unique case (idx)
         IDX_PINS:    rdata = pins_bus;
         IDX_ENA:     rdata = ena_q;
         IDX_LVLSEL:  rdata = lvl_q;
         IDX_POLAR:   rdata = pol_q;
         IDX_ANYEDGE: rdata = any_q;
         IDX_RAW:     rdata = raw_q;
         IDX_PEND:    rdata = pend;
         default:     rdata = '0;
      endcase
   end

   assign irq     = |pend;
   assign cfg_lvl = lvl_q;
   assign cfg_pol = pol_q;
   assign cfg_any = any_q;

   // R3: set status bits survive unless acknowledged
   a_r3_raw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ((raw_q & ~ack_v) != '0) |=>
      ((raw_q & $past(raw_q & ~ack_v)) == $past(raw_q & ~ack_v)));
   // R7: acknowledged bits without a concurrent hit drop
   a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ((ack_v & ~hit) != '0) |=> ((raw_q & $past(ack_v & ~hit)) == '0));
   // R9: a status bit only rises after a trigger hit
   a_r9_raw_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_q & ~$past(raw_q) & ~$past(hit)) == '0);
   // R8: a zero enable mask keeps the interrupt low
   a_r8_mask_gates_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (ena_q == '0) |-> !irq);
endmodule

// File: rtl/irq_bank.sv
module irq_bank
   import irqb_pkg::*;
#(
   parameter int CHANNELS     = 8,
   parameter int SYNC_STAGES  = 2,
   parameter bit SLOW_CAPTURE = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap_clk,
   input  logic [CHANNELS-1:0] pin_in,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    reg_idx,
   input  logic [CHANNELS-1:0] wdata,
   output logic [CHANNELS-1:0] rdata,
   output logic                irq
);
   localparam int CH = CHANNELS;

   generate
      if (CHANNELS < 1 || CHANNELS > 32) begin : g_bad_ch
         $error("irq_bank: CHANNELS must be 1..32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("irq_bank: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic          cclk;
   logic [CH-1:0] cfg_lvl, cfg_pol, cfg_any;
   logic [CH-1:0] now, edge_hit, lvl_hit;
   logic [CH-1:0] edge_bus, lvl_bus, pins_bus;

   assign cclk = SLOW_CAPTURE ? cap_clk : clk;

   irqb_capture #(.CH(CH), .STAGES(SYNC_STAGES)) u_capture (
      .cclk(cclk), .rst_n(rst_n), .pin_in(pin_in),
      .cfg_lvl(cfg_lvl), .cfg_pol(cfg_pol), .cfg_any(cfg_any),
      .now(now), .edge_hit(edge_hit), .lvl_hit(lvl_hit)
   );

   generate
      if (SLOW_CAPTURE) begin : g_slow
         irqb_xfer #(.CH(CH), .STAGES(SYNC_STAGES)) u_xfer (
            .clk(clk), .cclk(cclk), .rst_n(rst_n),
            .edge_hit(edge_hit), .lvl_hit(lvl_hit), .now(now),
            .edge_bus(edge_bus), .lvl_bus(lvl_bus), .pins_bus(pins_bus)
         );
      end else begin : g_fast
         assign edge_bus = edge_hit;
         assign lvl_bus  = lvl_hit;
         assign pins_bus = now;
      end
   endgenerate

   irqb_regs #(.CH(CH)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_idx(reg_idx),
      .wdata(wdata), .edge_bus(edge_bus), .lvl_bus(lvl_bus),
      .pins_bus(pins_bus), .cfg_lvl(cfg_lvl), .cfg_pol(cfg_pol),
      .cfg_any(cfg_any), .rdata(rdata), .irq(irq)
   );

   // R1: interrupt is low in the first cycle out of reset
   a_r1_irq_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !irq);
endmodule

// File: tb/irq_bank_tb.sv
`timescale 1ns/1ps
module irq_bank_tb;
   logic       clk = 1'b0;
   logic       cap_clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] pin_in = '0, pin_slow = '0;
   logic       wr_en = 1'b0;
   logic [2:0] reg_idx = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata, rdata_slow;
   logic       irq, irq_slow;

   int checks = 0, fails = 0;
   bit started = 1'b0;

   always #5  clk = ~clk;
   always #35 cap_clk = ~cap_clk;

   irq_bank u_dut (
      .clk(clk), .rst_n(rst_n), .cap_clk(cap_clk), .pin_in(pin_in),
      .wr_en(wr_en), .reg_idx(reg_idx), .wdata(wdata),
      .rdata(rdata), .irq(irq)
   );

   irq_bank #(.SLOW_CAPTURE(1'b1)) u_slow (
      .clk(clk), .rst_n(rst_n), .cap_clk(cap_clk), .pin_in(pin_slow),
      .wr_en(wr_en), .reg_idx(reg_idx), .wdata(wdata),
      .rdata(rdata_slow), .irq(irq_slow)
   );

   // Behavioural reference for the fast instance: a queue of sampled pins.
   logic [7:0] pin_hist[$];
   logic [7:0] m_ena, m_lvl, m_pol, m_any, m_raw;

   function automatic logic [7:0] m_hits(logic [7:0] cur, logic [7:0] old);
      logic [7:0] h;
      for (int b = 0; b < 8; b++) begin
         if (m_any[b])      h[b] = (cur[b] != old[b]);
         else if (m_lvl[b]) h[b] = (cur[b] == m_pol[b]);
         else if (m_pol[b]) h[b] = cur[b] && !old[b];
         else               h[b] = !cur[b] && old[b];
      end
      return h;
   endfunction

   function automatic logic [7:0] m_read(logic [2:0] i);
      case (i)
         3'd0: return pin_hist[1];
         3'd1: return m_ena;
         3'd2: return m_lvl;
         3'd3: return m_pol;
         3'd4: return m_any;
         3'd5: return m_raw;
         3'd6: return m_raw & m_ena;
         default: return 8'h00;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         pin_hist = '{8'h00, 8'h00, 8'h00};
         m_ena = '0; m_lvl = '0; m_pol = '0; m_any = '0; m_raw = '0;
      end else begin
         logic [7:0] h, clr;
         // pin_hist[1] is the synchronized level, pin_hist[2] the one before
         h   = m_hits(pin_hist[1], pin_hist[2]);
         clr = (wr_en && reg_idx == 3'd7) ? wdata : 8'h00;
         m_raw = (m_raw & ~clr) | h;
         if (wr_en) begin
            case (reg_idx)
               3'd1: m_ena = wdata;
               3'd2: m_lvl = wdata;
               3'd3: m_pol = wdata;
               3'd4: m_any = wdata;
               default: ;
            endcase
         end
         pin_hist.push_front(pin_in);
         void'(pin_hist.pop_back());
      end
   end

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Model compare every cycle, away from the active edge.
   always @(negedge clk) begin
      if (started && rst_n) begin
         chk("model rdata", rdata, m_read(reg_idx));
         chk("model R8 irq", {7'b0, irq}, {7'b0, |(m_raw & m_ena)});
      end
   end

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wr(logic [2:0] i, logic [7:0] v);
      wr_en = 1'b1; reg_idx = i; wdata = v;
      tick(1);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rd(logic [2:0] i, logic [7:0] exp, string tag);
      reg_idx = i;
      #1;
      chk(tag, rdata, exp);
   endtask

   task automatic rd_slow(logic [2:0] i, logic [7:0] exp, string tag);
      reg_idx = i;
      #1;
      chk(tag, rdata_slow, exp);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      started = 1'b1;
      tick(1);
      // R1 reset state
      for (int i = 0; i < 8; i++) rd(3'(i), 8'h00, "R1 reset register");
      chk("R1 irq after reset", {7'b0, irq}, 8'h00);

      wr(3'd1, 8'hFF);
      // R2 synchronizer delay; default falling trigger ignores rises (R4)
      pin_in = 8'hA5;
      tick(1); rd(3'd0, 8'h00, "R2 pins after one edge");
      tick(1); rd(3'd0, 8'hA5, "R2 pins after two edges");
      tick(1); rd(3'd5, 8'h00, "R4 rise ignored in falling mode");
      pin_in = 8'h00;
      tick(3); rd(3'd5, 8'hA5, "R4 falling edge sets raw");
      chk("R8 irq with pending", {7'b0, irq}, 8'h01);
      wr(3'd7, 8'hFF); rd(3'd5, 8'h00, "R7 ack clears all");

      // R3 rising edges, sticky
      wr(3'd3, 8'hFF);
      pin_in = 8'h3C;
      tick(3); rd(3'd5, 8'h3C, "R3 rising edge sets raw");
      wr(3'd1, 8'h0C); rd(3'd6, 8'h0C, "R8 pend masked");
      chk("R8 irq partial mask", {7'b0, irq}, 8'h01);
      wr(3'd1, 8'h00); rd(3'd6, 8'h00, "R8 pend fully masked");
      chk("R8 irq masked off", {7'b0, irq}, 8'h00);
      wr(3'd1, 8'hFF);
      pin_in = 8'h00;
      tick(3); rd(3'd5, 8'h3C, "R3 raw sticky after input drops");
      wr(3'd7, 8'h0C); rd(3'd5, 8'h30, "R7 partial ack");
      wr(3'd7, 8'h00); rd(3'd5, 8'h30, "R7 zero ack no effect");
      wr(3'd7, 8'hFF); rd(3'd5, 8'h00, "R7 full ack");

      // R5 any-edge overrides level-low on channel 0
      wr(3'd4, 8'h01); wr(3'd2, 8'h01); wr(3'd3, 8'h00);
      tick(2); rd(3'd5, 8'h00, "R5 steady input no hit");
      pin_in = 8'h01;
      tick(3); rd(3'd5, 8'h01, "R5 rise with any-edge");
      wr(3'd7, 8'hFF); rd(3'd5, 8'h00, "R7 ack after any-edge");
      pin_in = 8'h00;
      tick(3); rd(3'd5, 8'h01, "R5 fall with any-edge");
      wr(3'd2, 8'h00); wr(3'd4, 8'h00); wr(3'd7, 8'hFF);
      rd(3'd5, 8'h00, "R7 cleared before level test");

      // R6 level triggering
      wr(3'd3, 8'hFF); wr(3'd2, 8'hFF);
      pin_in = 8'h81;
      tick(3); rd(3'd5, 8'h81, "R6 level high sets raw");
      wr(3'd7, 8'hFF); rd(3'd5, 8'h81, "R6 ack during level reasserts");
      pin_in = 8'h00;
      tick(3); rd(3'd5, 8'h81, "R6 raw held after level ends");
      wr(3'd7, 8'hFF); rd(3'd5, 8'h00, "R6 ack after level ends");
      wr(3'd3, 8'h00); rd(3'd5, 8'h00, "R6 level low not yet seen");
      tick(1); rd(3'd5, 8'hFF, "R6 level low sets raw");
      wr(3'd2, 8'h00); wr(3'd7, 8'hFF); wr(3'd3, 8'hFF);
      rd(3'd5, 8'h00, "R6 cleared after leaving level");

      // R7 hit and ack in the same cycle
      pin_in = 8'h10;
      tick(2); wr(3'd7, 8'hFF);
      rd(3'd5, 8'h10, "R7 hit wins over ack");
      wr(3'd7, 8'hFF); rd(3'd5, 8'h00, "R7 ack after collision");

      // R9 read-only and write-only registers
      wr(3'd5, 8'hFF); rd(3'd5, 8'h00, "R9 raw not writable");
      wr(3'd6, 8'hFF); rd(3'd6, 8'h00, "R9 pend not writable");
      wr(3'd0, 8'h00); rd(3'd0, 8'h10, "R9 pins not writable");
      rd(3'd7, 8'h00, "R9 ack reads zero");
      rd(3'd1, 8'hFF, "R9 enable readback");

      // R10 slow capture variant
      tick(40); wr(3'd7, 8'hFF); tick(40);
      rd_slow(3'd5, 8'h00, "R10 slow idle");
      pin_slow = 8'h04;
      tick(60); rd_slow(3'd5, 8'h04, "R10 slow rising edge arrives");
      chk("R10 slow irq", {7'b0, irq_slow}, 8'h01);
      wr(3'd7, 8'hFF);
      tick(60); rd_slow(3'd5, 8'h00, "R10 slow event delivered once");
      rd_slow(3'd0, 8'h04, "R10 slow pins");

      finish_run();
   end
endmodule